// File: doc/BRIEF.md
# System Bus Access Master for a Debug Port

This block gives a debugger a path onto the system bus that does not go through any processor core. The debugger drives a small register file with single-cycle register reads and writes. The registers are a control word, four 32-bit address words and two 32-bit data words. From that traffic the block issues single read or write transactions of 8, 16, 32 or 64 bits. A transaction holds its request until the bus acknowledges it. The acknowledge can report a fault.

Transactions start as side effects of register traffic. A write to the low data word starts a bus write. A write to the low address word can start a bus read. A read of the low data word returns the value held now and can also start the next read. After each successful access the address can step forward by the access size, with carry through all four address words. Any error is held until software clears it, and it blocks further transactions. The supported access widths and the address width are reported as constants in the control word.

Top module: `sba_master`

## Requirements
- R1: After reset the control word reads 0x00040F00 for a 64-bit bus: only the constant fields are set. The address words and data words read 0 and no bus request is raised.
- R2: Control bits [1:0] select the access width as 8 << code bits, and bus_size_o carries that code. If the selected width is wider than MAX_BUS_BITS, a triggering access raises no request and sets the error field to 2 (size error).
- R3: Control bits [11:8] report widths 8, 16, 32 and 64, from bit 8 upward. Each bit is set when that width is no wider than MAX_BUS_BITS. Bits [18:12] read 64, the bus address width.
- R4: The bus address is address word 1 (register 2) as the upper half and address word 0 (register 1) as the lower half.
- R5: With control bit 3 (read on address write) set and the error field at zero, a write to register 1 starts a bus read at the newly written address. With bit 3 clear, no read starts.
- R6: With the error field at zero, a write to register 5 (data word 0) starts a bus write. For 64-bit width the write data is {register 6, new data word 0}; otherwise it is data word 0 zero-extended.
- R7: A read of register 5 returns its current value. With control bit 4 (read on data read) set and the error field at zero, the read also starts a bus read.
- R8: When a read completes without fault, the width sets what is kept. For 8, 16 and 32 bits, data word 0 takes bus_rdata_i masked to that width. For 64 bits, data word 0 takes the low half and data word 1 takes the high half.
- R9: With control bit 2 (auto-increment) set, a successful access adds (1 << width code) to the 128-bit value formed by the four address words, with carry from word 0 through word 3.
- R10: A faulted acknowledge sets the error field (bits [6:5]) to 1 and leaves the address and data words unchanged. While the error field is non-zero, no trigger starts a transaction.
- R11: In a write to register 0, every 1 in bits [6:5] clears that error bit. The other writable fields take the written value.
- R12: While a request is pending, bit 7 of the control word reads 1 and the bus outputs hold. Register writes in that state are dropped, and no trigger starts a new transaction. This includes a write that lands in the acknowledge cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| reg_we_i | input | 1 | Register write strobe |
| reg_re_i | input | 1 | Register read strobe (needed only for the data-read trigger) |
| reg_addr_i | input | 3 | Register index: 0 control, 1..4 address words 0..3, 5..6 data words 0..1 |
| reg_wdata_i | input | 32 | Register write data |
| reg_rdata_o | output | 32 | Register read data for reg_addr_i, combinational |
| bus_req_o | output | 1 | Transaction pending |
| bus_we_o | output | 1 | 1 for write, 0 for read |
| bus_addr_o | output | 64 | Transaction address |
| bus_size_o | output | 2 | Width code, bytes = 1 << code |
| bus_wdata_o | output | 64 | Write data |
| bus_ack_i | input | 1 | Transaction completes this cycle |
| bus_err_i | input | 1 | Completing transaction faulted |
| bus_rdata_i | input | 64 | Read data, valid with bus_ack_i |

## Verification
The conflict that needs watching is a bus acknowledge, with or without a fault, in the same cycle as a register write. The acknowledge may auto-increment the address or load the data words while the write targets those same registers. The bench stretches bus latency to several cycles and issues an unbroken run of address-word writes that spans the pending cycles and the acknowledge cycle. It then checks that none of those writes landed. A behavioural model compares the register readback and every bus output on every clock. It also confirms that writes made after the acknowledge take effect as normal.

// File: rtl/sba_pkg.sv
package sba_pkg;
  localparam logic [2:0] REG_CTRL  = 3'd0;
  localparam logic [2:0] REG_ADDR0 = 3'd1;
  localparam logic [2:0] REG_ADDR1 = 3'd2;
  localparam logic [2:0] REG_ADDR2 = 3'd3;
  localparam logic [2:0] REG_ADDR3 = 3'd4;
  localparam logic [2:0] REG_DATA0 = 3'd5;
  localparam logic [2:0] REG_DATA1 = 3'd6;

  localparam int ADDR_WORDS = 4;
  localparam int BUS_AW     = 64;
  localparam int BUS_DW     = 64;

  typedef enum logic [1:0] {
    ERR_NONE = 2'd0,
    ERR_BUS  = 2'd1,
    ERR_SIZE = 2'd2
  } err_e;
endpackage

// File: rtl/sba_caps.sv
module sba_caps #(
  parameter int MAX_BUS_BITS = 64
) (
  output logic [3:0] caps_o
);
  for (genvar i = 0; i < 4; i++) begin : g_cap
    assign caps_o[i] = ((8 << i) <= MAX_BUS_BITS);
  end
endmodule

// File: rtl/sba_addr_inc.sv
module sba_addr_inc #(
  parameter int NW = 4
) (
  input  logic [NW*32-1:0] addr_i,
  input  logic [3:0]       step_i,
  output logic [NW*32-1:0] addr_o
);
  logic [NW-1:1] cy;

  for (genvar w = 0; w < NW; w++) begin : g_word
    logic [31:0] add;
    if (w == 0) begin : g_lo
      assign add = {28'b0, step_i};
    end else begin : g_hi
      assign add = {31'b0, cy[w]};
    end
    if (w < NW - 1) begin : g_carry
      assign {cy[w+1], addr_o[w*32+:32]} = {1'b0, addr_i[w*32+:32]} + {1'b0, add};
    end else begin : g_top
      assign addr_o[w*32+:32] = addr_i[w*32+:32] + add;
    end
  end
endmodule

// File: rtl/sba_bus_port.sv
module sba_bus_port #(
  parameter int MAX_BUS_BITS = 64
) (
  input  logic                      clk_i,
  input  logic                      rst_ni,
  input  logic                      start_i,
  input  logic                      we_i,
  input  logic [sba_pkg::BUS_AW-1:0] addr_i,
  input  logic [1:0]                size_i,
  input  logic [sba_pkg::BUS_DW-1:0] wdata_i,
  output logic                      bus_req_o,
  output logic                      bus_we_o,
  output logic [sba_pkg::BUS_AW-1:0] bus_addr_o,
  output logic [1:0]                bus_size_o,
  output logic [sba_pkg::BUS_DW-1:0] bus_wdata_o,
  input  logic                      bus_ack_i,
  input  logic                      bus_err_i,
  input  logic [sba_pkg::BUS_DW-1:0] bus_rdata_i,
  output logic                      done_o,
  output logic                      fault_o,
  output logic [sba_pkg::BUS_DW-1:0] rdata_o
);
  logic busy_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      busy_q      <= 1'b0;
      bus_we_o    <= 1'b0;
      bus_addr_o  <= '0;
      bus_size_o  <= '0;
      bus_wdata_o <= '0;
    end else if (start_i) begin
      busy_q      <= 1'b1;
      bus_we_o    <= we_i;
      bus_addr_o  <= addr_i;
      bus_size_o  <= size_i;
      bus_wdata_o <= wdata_i;
    end else if (busy_q && bus_ack_i) begin
      busy_q <= 1'b0;
    end
  end

  assign bus_req_o = busy_q;
  assign done_o    = busy_q & bus_ack_i;
  assign fault_o   = done_o & bus_err_i;

  always_comb begin
    unique case (bus_size_o)
      2'd0:    rdata_o = {56'b0, bus_rdata_i[7:0]};
      2'd1:    rdata_o = {48'b0, bus_rdata_i[15:0]};
      2'd2:    rdata_o = {32'b0, bus_rdata_i[31:0]};
      default: rdata_o = bus_rdata_i;
    endcase
  end

  p_start_idle_r12: assert property (@(posedge clk_i) disable iff (!rst_ni)
    start_i |-> !bus_req_o);
  p_hold_r12: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (bus_req_o && !bus_ack_i) |=> (bus_req_o && $stable(bus_addr_o) && $stable(bus_wdata_o)
                                   && $stable(bus_size_o) && $stable(bus_we_o)));
  p_legal_size_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    bus_req_o |-> ((8 << bus_size_o) <= MAX_BUS_BITS));
endmodule

// File: rtl/sba_master.sv
module sba_master
  import sba_pkg::*;
#(
  parameter int MAX_BUS_BITS = 64
) (
  input  logic        clk_i,
  input  logic        rst_ni,
  input  logic        reg_we_i,
  input  logic        reg_re_i,
  input  logic [2:0]  reg_addr_i,
  input  logic [31:0] reg_wdata_i,
  output logic [31:0] reg_rdata_o,
  output logic        bus_req_o,
  output logic        bus_we_o,
  output logic [63:0] bus_addr_o,
  output logic [1:0]  bus_size_o,
  output logic [63:0] bus_wdata_o,
  input  logic        bus_ack_i,
  input  logic        bus_err_i,
  input  logic [63:0] bus_rdata_i
);
  localparam int AW_ALL = ADDR_WORDS * 32;

  logic [1:0]        size_q;
  logic              ai_q, roa_q, rod_q;
  err_e              err_q;
  logic [AW_ALL-1:0] addr_q, addr_wr, addr_inc;
  logic [63:0]       data_q, data_wr, start_wdata, rd_masked;
  logic [3:0]        caps;
  logic              idle, wr_ok, rd_trig, wr_trig, trig, size_ok, start, size_fail;
  logic              done, fault;

  sba_caps #(.MAX_BUS_BITS(MAX_BUS_BITS)) u_caps (.caps_o(caps));

  sba_addr_inc #(.NW(ADDR_WORDS)) u_inc (
    .addr_i(addr_q),
    .step_i(4'd1 << bus_size_o),
    .addr_o(addr_inc)
  );

  assign idle  = ~bus_req_o;
  assign wr_ok = reg_we_i & idle;

  always_comb begin
    addr_wr = addr_q;
    data_wr = data_q;
    if (wr_ok) begin
      unique case (reg_addr_i)
        REG_ADDR0: addr_wr[31:0]   = reg_wdata_i;
        REG_ADDR1: addr_wr[63:32]  = reg_wdata_i;
        REG_ADDR2: addr_wr[95:64]  = reg_wdata_i;
        REG_ADDR3: addr_wr[127:96] = reg_wdata_i;
        REG_DATA0: data_wr[31:0]   = reg_wdata_i;
        REG_DATA1: data_wr[63:32]  = reg_wdata_i;
        default: ;
      endcase
    end
  end

  assign rd_trig = (err_q == ERR_NONE) &
                   ((wr_ok & (reg_addr_i == REG_ADDR0) & roa_q) |
                    (reg_re_i & idle & (reg_addr_i == REG_DATA0) & rod_q));
  assign wr_trig   = (err_q == ERR_NONE) & wr_ok & (reg_addr_i == REG_DATA0);
  assign trig      = rd_trig | wr_trig;
  assign size_ok   = caps[size_q];
  assign start     = trig & size_ok;
  assign size_fail = trig & ~size_ok;
  assign start_wdata = (size_q == 2'd3) ? data_wr : {32'b0, data_wr[31:0]};

  sba_bus_port #(.MAX_BUS_BITS(MAX_BUS_BITS)) u_port (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .start_i    (start),
    .we_i       (wr_trig),
    .addr_i     (addr_wr[63:0]),
    .size_i     (size_q),
    .wdata_i    (start_wdata),
    .bus_req_o  (bus_req_o),
    .bus_we_o   (bus_we_o),
    .bus_addr_o (bus_addr_o),
    .bus_size_o (bus_size_o),
    .bus_wdata_o(bus_wdata_o),
    .bus_ack_i  (bus_ack_i),
    .bus_err_i  (bus_err_i),
    .bus_rdata_i(bus_rdata_i),
    .done_o     (done),
    .fault_o    (fault),
    .rdata_o    (rd_masked)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      size_q <= '0;
      ai_q   <= 1'b0;
      roa_q  <= 1'b0;
      rod_q  <= 1'b0;
      err_q  <= ERR_NONE;
      addr_q <= '0;
      data_q <= '0;
    end else if (done) begin
      if (fault) begin
        err_q <= ERR_BUS;
      end else begin
        if (!bus_we_o) begin
          if (bus_size_o == 2'd3) data_q <= rd_masked;
          else                    data_q[31:0] <= rd_masked[31:0];
        end
        if (ai_q) addr_q <= addr_inc;
      end
    end else begin
      addr_q <= addr_wr;
      data_q <= data_wr;
      if (wr_ok && reg_addr_i == REG_CTRL) begin
        size_q <= reg_wdata_i[1:0];
        ai_q   <= reg_wdata_i[2];
        roa_q  <= reg_wdata_i[3];
        rod_q  <= reg_wdata_i[4];
        err_q  <= err_e'(err_q & ~reg_wdata_i[6:5]);
      end
      if (size_fail) err_q <= ERR_SIZE;
    end
  end

  always_comb begin
    unique case (reg_addr_i)
      REG_CTRL:  reg_rdata_o = {13'b0, 7'd64, caps, bus_req_o, err_q, rod_q, roa_q, ai_q, size_q};
      REG_ADDR0: reg_rdata_o = addr_q[31:0];
      REG_ADDR1: reg_rdata_o = addr_q[63:32];
      REG_ADDR2: reg_rdata_o = addr_q[95:64];
      REG_ADDR3: reg_rdata_o = addr_q[127:96];
      REG_DATA0: reg_rdata_o = data_q[31:0];
      REG_DATA1: reg_rdata_o = data_q[63:32];
      default:   reg_rdata_o = 32'b0;
    endcase
  end

  p_inc_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (done && !fault && ai_q) |=>
      (addr_q[31:0] == $past(addr_q[31:0]) + (32'd1 << $past(bus_size_o))));
  p_fault_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    fault |=> (err_q == ERR_BUS && $stable(addr_q) && $stable(data_q)));
  p_err_block_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (err_q != ERR_NONE && !bus_req_o) |=> !bus_req_o);
  p_size_err_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    size_fail |=> (!bus_req_o && err_q == ERR_SIZE));
  p_w1c_r11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_ok && reg_addr_i == REG_CTRL) |=>
      (err_q == ($past(err_q) & ~$past(reg_wdata_i[6:5]))));
endmodule

// File: tb/sim_sba_master.sv
`timescale 1ns/1ps
module sim_sba_master;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        we = 1'b0, re = 1'b0;
  logic [2:0]  ra = 3'd0;
  logic [31:0] wd = 32'd0;
  logic [31:0] rd;
  logic        b_req, b_we;
  logic [63:0] b_addr, b_wdata;
  logic [1:0]  b_size;
  logic        b_ack = 1'b0, b_err = 1'b0;
  logic [63:0] b_rdata = 64'd0;

  logic        we1 = 1'b0;
  logic [2:0]  ra1 = 3'd0;
  logic [31:0] wd1 = 32'd0;
  logic [31:0] rd1;
  logic        req1, we1_o;
  logic [63:0] addr1, wdata1;
  logic [1:0]  size1;

  int n_chk = 0, n_fail = 0, cyc = 0, lat = 1, wcnt = 0;

  always #2.5 clk = ~clk;

  sba_master u0 (
    .clk_i(clk), .rst_ni(rst_n), .reg_we_i(we), .reg_re_i(re), .reg_addr_i(ra),
    .reg_wdata_i(wd), .reg_rdata_o(rd), .bus_req_o(b_req), .bus_we_o(b_we),
    .bus_addr_o(b_addr), .bus_size_o(b_size), .bus_wdata_o(b_wdata),
    .bus_ack_i(b_ack), .bus_err_i(b_err), .bus_rdata_i(b_rdata));

  sba_master #(.MAX_BUS_BITS(16)) u1 (
    .clk_i(clk), .rst_ni(rst_n), .reg_we_i(we1), .reg_re_i(1'b0), .reg_addr_i(ra1),
    .reg_wdata_i(wd1), .reg_rdata_o(rd1), .bus_req_o(req1), .bus_we_o(we1_o),
    .bus_addr_o(addr1), .bus_size_o(size1), .bus_wdata_o(wdata1),
    .bus_ack_i(req1), .bus_err_i(1'b0), .bus_rdata_i(64'd0));

  task automatic chk(input string tag, input logic [63:0] act, input logic [63:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  // bus responder: ack after lat cycles, fault on 0xEE______ addresses
  always @(negedge clk) begin
    if (b_ack) begin
      b_ack = 1'b0; wcnt = 0;
    end else if (b_req) begin
      if (wcnt >= lat) begin
        b_ack   = 1'b1;
        b_err   = (b_addr[31:24] == 8'hEE);
        b_rdata = {~b_addr[31:0], b_addr[31:0] ^ 32'h5A5A_0000};
      end else wcnt++;
    end
  end

  // behavioural reference model
  logic [1:0]   m_size, m_bsize;
  logic         m_ai, m_roa, m_rod, m_busy, m_bwe;
  logic [1:0]   m_err;
  logic [127:0] m_addr;
  logic [63:0]  m_data, m_baddr, m_bwdata;

  function automatic logic [31:0] m_read(input logic [2:0] a);
    case (a)
      3'd0: return {13'b0, 7'd64, 4'hF, m_busy, m_err, m_rod, m_roa, m_ai, m_size};
      3'd1: return m_addr[31:0];
      3'd2: return m_addr[63:32];
      3'd3: return m_addr[95:64];
      3'd4: return m_addr[127:96];
      3'd5: return m_data[31:0];
      3'd6: return m_data[63:32];
      default: return 32'd0;
    endcase
  endfunction

  always @(posedge clk) begin
    if (!rst_n) begin
      m_size = 0; m_ai = 0; m_roa = 0; m_rod = 0; m_busy = 0; m_bwe = 0; m_bsize = 0;
      m_err = 0; m_addr = 0; m_data = 0; m_baddr = 0; m_bwdata = 0;
    end else begin
      bit go_rd, go_wr;
      go_rd = 0; go_wr = 0;
      if (m_busy) begin
        if (b_ack) begin
          m_busy = 0;
          if (b_err) m_err = 2'd1;
          else begin
            if (!m_bwe) begin
              if (m_bsize == 3) m_data = b_rdata;
              else m_data[31:0] = b_rdata[31:0] & ((64'd1 << (8 << m_bsize)) - 1);
            end
            if (m_ai) m_addr = m_addr + (128'd1 << m_bsize);
          end
        end
      end else begin
        if (we) begin
          case (ra)
            3'd0: begin m_size = wd[1:0]; m_ai = wd[2]; m_roa = wd[3]; m_rod = wd[4];
                        m_err = m_err & ~wd[6:5]; end
            3'd1: begin m_addr[31:0] = wd; go_rd = m_roa; end
            3'd2: m_addr[63:32] = wd;
            3'd3: m_addr[95:64] = wd;
            3'd4: m_addr[127:96] = wd;
            3'd5: begin m_data[31:0] = wd; go_wr = 1; end
            3'd6: m_data[63:32] = wd;
            default: ;
          endcase
        end
        if (re && ra == 3'd5 && m_rod) go_rd = 1;
        if ((go_rd || go_wr) && m_err == 0) begin
          if (m_size == 3 || (8 << m_size) > 64) m_err = (8 << m_size) > 64 ? 2'd2 : m_err;
          if ((8 << m_size) <= 64) begin
            m_busy = 1; m_bwe = go_wr; m_bsize = m_size; m_baddr = m_addr[63:0];
            m_bwdata = (m_size == 3) ? m_data : {32'd0, m_data[31:0]};
          end
        end
      end
      cyc++;
      #1;
      chk("R4/R8/R9/R12 model req", b_req, m_busy);
      chk("R1/R3/R9/R12 model readback", rd, m_read(ra));
      if (m_busy) begin
        chk("R4 model addr", b_addr, m_baddr);
        chk("R2 model size", b_size, m_bsize);
        chk("R5/R6 model dir", b_we, m_bwe);
        if (m_bwe) chk("R6 model wdata", b_wdata, m_bwdata);
      end
    end
  end

  task automatic wr(input logic [2:0] a, input logic [31:0] v);
    @(negedge clk); ra = a; wd = v; we = 1'b1;
    @(negedge clk); we = 1'b0;
  endtask

  task automatic wr1(input logic [2:0] a, input logic [31:0] v);
    @(negedge clk); ra1 = a; wd1 = v; we1 = 1'b1;
    @(negedge clk); we1 = 1'b0;
  endtask

  task automatic rdv(input logic [2:0] a, output logic [31:0] v);
    ra = a; #1 v = rd;
  endtask

  task automatic wait_idle;
    for (int i = 0; i < 20 && b_req; i++) @(negedge clk);
  endtask

  initial begin
    logic [31:0] v;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // reset state and capabilities
    rdv(3'd0, v); chk("R1 R3 ctrl after reset", v, 32'h0004_0F00);
    rdv(3'd1, v); chk("R1 addr0 after reset", v, 0);
    rdv(3'd5, v); chk("R1 data0 after reset", v, 0);
    chk("R1 no request", b_req, 0);
    ra1 = 3'd0; #1 chk("R3 caps for 16-bit bus", rd1, 32'h0004_0300);
    // size error on narrow instance
    wr1(3'd0, 32'h2); wr1(3'd5, 32'h5);
    chk("R2 no request on size error", req1, 0);
    ra1 = 3'd0; #1 chk("R2 size error code", rd1, 32'h0004_0342);
    wr1(3'd0, 32'h62);
    ra1 = 3'd0; #1 chk("R11 clear size error", rd1, 32'h0004_0302);
    // plain 32-bit write
    wr(3'd0, 32'h2); wr(3'd2, 0); wr(3'd1, 32'h1000);
    chk("R5 no read without flag", b_req, 0);
    wr(3'd5, 32'hCAFE_BABE);
    chk("R6 write starts", b_req, 1);
    chk("R6 write dir", b_we, 1);
    chk("R4 write addr", b_addr, 64'h1000);
    chk("R6 write data", b_wdata, 64'hCAFE_BABE);
    rdv(3'd0, v); chk("R12 busy bit", v[7], 1);
    wait_idle;
    // 64-bit write with increment
    wr(3'd0, 32'h7); wr(3'd6, 32'h1111_2222); wr(3'd5, 32'h3333_4444);
    chk("R6 64-bit data", b_wdata, 64'h1111_2222_3333_4444);
    chk("R2 size code 3", b_size, 3);
    wait_idle;
    rdv(3'd1, v); chk("R9 increment by 8", v, 32'h1008);
    // carry across all words
    wr(3'd1, 32'hFFFF_FFFC); wr(3'd2, 32'hFFFF_FFFF); wr(3'd3, 32'hFFFF_FFFF); wr(3'd4, 5);
    wr(3'd0, 32'h6); wr(3'd5, 1);
    chk("R4 full address", b_addr, 64'hFFFF_FFFF_FFFF_FFFC);
    wait_idle;
    rdv(3'd1, v); chk("R9 carry word0", v, 0);
    rdv(3'd2, v); chk("R9 carry word1", v, 0);
    rdv(3'd3, v); chk("R9 carry word2", v, 0);
    rdv(3'd4, v); chk("R9 carry word3", v, 6);
    // read on address write
    wr(3'd0, 32'hE); wr(3'd1, 32'h2000);
    chk("R5 read starts", b_req, 1);
    chk("R5 read dir", b_we, 0);
    chk("R5 read at new addr", b_addr, 64'h2000);
    wait_idle;
    rdv(3'd5, v); chk("R8 32-bit read data", v, 32'h5A5A_2000);
    rdv(3'd1, v); chk("R9 increment by 4", v, 32'h2004);
    wr(3'd0, 32'h8); wr(3'd1, 32'h2003); wait_idle;
    rdv(3'd5, v); chk("R8 8-bit mask", v, 32'h3);
    rdv(3'd1, v); chk("R9 no increment when off", v, 32'h2003);
    wr(3'd0, 32'hB); wr(3'd1, 32'h3000); wait_idle;
    rdv(3'd5, v); chk("R8 64-bit low", v, 32'h5A5A_3000);
    rdv(3'd6, v); chk("R8 64-bit high", v, 32'hFFFF_CFFF);
    // read on data read
    wr(3'd0, 32'h16); wr(3'd1, 32'h4000);
    chk("R5 no read with flag clear", b_req, 0);
    @(negedge clk); ra = 3'd5; re = 1'b1; #1 v = rd;
    chk("R7 returns current value", v, 32'h5A5A_3000);
    @(negedge clk); re = 1'b0;
    chk("R7 read triggered", b_req, 1);
    wait_idle;
    rdv(3'd5, v); chk("R7 next value loaded", v, 32'h5A5A_4000);
    rdv(3'd1, v); chk("R9 step after data read", v, 32'h4004);
    // writes while pending, including the acknowledge cycle
    lat = 3;
    wr(3'd0, 32'h2); wr(3'd5, 32'h99);
    @(negedge clk); ra = 3'd3; wd = 32'hDEAD_0001; we = 1'b1;
    @(negedge clk); wd = 32'hDEAD_0002;
    @(negedge clk); wd = 32'hDEAD_0003;
    @(negedge clk); we = 1'b0;
    chk("R12 request done", b_req, 0);
    rdv(3'd3, v); chk("R12 writes dropped while pending", v, 0);
    lat = 1;
    // bus fault
    wr(3'd0, 32'hE); wr(3'd1, 32'hEE00_0000); wait_idle;
    rdv(3'd0, v); chk("R10 fault code", v, 32'h0004_0F2E);
    rdv(3'd1, v); chk("R10 no increment on fault", v, 32'hEE00_0000);
    rdv(3'd5, v); chk("R10 data untouched", v, 32'h99);
    wr(3'd5, 32'h77);
    chk("R10 error blocks write", b_req, 0);
    wr(3'd0, 32'h26);
    rdv(3'd0, v); chk("R11 clear fault", v, 32'h0004_0F06);
    wr(3'd1, 32'h5000); wr(3'd5, 32'h55);
    chk("R11 access resumes", b_req, 1);
    wait_idle;
    rdv(3'd1, v); chk("R9 after resume", v, 32'h5004);
    repeat (2) @(negedge clk);
    $display("TB_RESULT checks=%0d failures=%0d", n_chk, n_fail);
    $finish;
  end

  initial begin
    wait (cyc > 20000);
    n_chk++; n_fail++;
    $display("FAIL watchdog expired");
    $display("TB_RESULT checks=%0d failures=%0d", n_chk, n_fail);
    $finish;
  end
endmodule